// File: doc/BRIEF.md
# Special-Address Three-Port Register File

This block is the register file of a small execution unit. It stores 160 words of 32 bits. It has two combinational read ports, A and B, and one clocked write port, C. The three 8-bit addresses arrive together in a single packed address word. Most addresses behave as ordinary storage. A handful of addresses are decoded into their own behaviour:

- a sink that swallows writes;
- an address that forwards the written value to an outgoing bus port;
- a memory address register with its own output;
- a field register kept both in the array and in a separate copy;
- a word that always reads as zero.

Addresses at or above the array depth are illegal. The block flags them per port, reads from them return zero, and writes to them change nothing.

The surrounding datapath places A, B and C in the address word, presents the write data with a write enable, and takes the two read results in the same cycle. The forwarded value, the memory address register and the field register copy are exposed as ports. Neighbouring logic can use them without spending a read port.

Top module: `exu_regfile`

## Requirements
- R1: Addresses 0 to 127 are general storage. A write with `wr_en` high stores `wr_data` at the rising clock edge, and later reads of that address on either port return it.
- R2: A write to address 128 stores nothing, and reads of address 128 return zero.
- R3: While `wr_en` is high and the C address is 129, `fwd_valid` is 1 and `fwd_data` equals `wr_data` in that same cycle. Otherwise `fwd_valid` is 0 and `fwd_data` is zero. Nothing is stored, and reads of 129 return zero.
- R4: Address 130 is the memory address register. A write updates `mar_q` at the clock edge, and reads of 130 return `mar_q`.
- R5: Address 131 is the field register. A write updates both the array word and the copy on `fld_q` at the clock edge, and reads of 131 return the written value.
- R6: Address 132 always reads as zero, and writes to it are ignored.
- R7: Addresses 133 to 159 are ordinary storage with the same behaviour as R1.
- R8: An address of 160 or more is illegal. For a read port, the flag (`rd_a_bad` or `rd_b_bad`) is 1 in the same cycle and the read data is zero. For the write port, `wr_bad` is 1 while `wr_en` is high, and no storage, register or forward output changes.
- R9: `addr_word` carries the A address in bits 7:0, the B address in bits 15:8 and the C address in bits 23:16.
- R10: When a read address equals the write address in the same cycle, the read returns the value held before the write. There is no bypass.
- R11: An active-low reset clears `mar_q` and `fld_q` to zero.
- R12: With `wr_en` low, no storage or register changes, and `fwd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_word | input | 24 | Packed A, B and C addresses |
| wr_en | input | 1 | Write enable for port C |
| wr_data | input | 32 | Write data for port C |
| rd_a_data | output | 32 | Read result of port A |
| rd_b_data | output | 32 | Read result of port B |
| rd_a_bad | output | 1 | A address illegal |
| rd_b_bad | output | 1 | B address illegal |
| wr_bad | output | 1 | Write enabled to an illegal C address |
| fwd_valid | output | 1 | Write is being forwarded to the bus |
| fwd_data | output | 32 | Forwarded write value |
| mar_q | output | 32 | Memory address register |
| fld_q | output | 32 | Field register copy |

## Verification
The bench aims writes at each special address and at illegal addresses, then reads back every neighbouring word:

- A decoder that stored into 128, 129 or 132 would return non-zero data from them.
- An unguarded array index would return stale words for addresses at or above 160, or corrupt low words through wrap-around.
- A read bypass would show up as new data on a port whose address equals the write address.
- A field register that updated only one of its copies would make `fld_q` disagree with reads of 131.
- A forward output that ignored `wr_en` would pulse `fwd_valid` on idle cycles.

// File: rtl/exu_rf_pkg.sv
package exu_rf_pkg;
  localparam int RF_DW    = 32;
  localparam int RF_AW    = 8;
  localparam int RF_DEPTH = 160;

  localparam int RF_SINK_ADR = 128;
  localparam int RF_FWD_ADR  = 129;
  localparam int RF_MAR_ADR  = 130;
  localparam int RF_FLD_ADR  = 131;
  localparam int RF_ZERO_ADR = 132;

  typedef enum logic [2:0] {
    RC_STORE,
    RC_SINK,
    RC_FWD,
    RC_MAR,
    RC_FLD,
    RC_ZERO,
    RC_BAD
  } rf_class_e;
endpackage

// File: rtl/exu_rf_decode.sv
module exu_rf_decode
  import exu_rf_pkg::*;
#(
  parameter int AW       = RF_AW,
  parameter int DEPTH    = RF_DEPTH,
  parameter int SINK_ADR = RF_SINK_ADR,
  parameter int FWD_ADR  = RF_FWD_ADR,
  parameter int MAR_ADR  = RF_MAR_ADR,
  parameter int FLD_ADR  = RF_FLD_ADR,
  parameter int ZERO_ADR = RF_ZERO_ADR
) (
  input  logic [AW-1:0] addr,
  output rf_class_e     cls
);
  localparam int AXW = AW + 1;

  logic [AXW-1:0] addr_x;
  assign addr_x = {1'b0, addr};

  always_comb begin
    if (addr_x >= AXW'(DEPTH))         cls = RC_BAD;
    else if (addr_x == AXW'(SINK_ADR)) cls = RC_SINK;
    else if (addr_x == AXW'(FWD_ADR))  cls = RC_FWD;
    else if (addr_x == AXW'(MAR_ADR))  cls = RC_MAR;
    else if (addr_x == AXW'(FLD_ADR))  cls = RC_FLD;
    else if (addr_x == AXW'(ZERO_ADR)) cls = RC_ZERO;
    else                               cls = RC_STORE;
  end
endmodule

// File: rtl/exu_rf_array.sv
module exu_rf_array
  import exu_rf_pkg::*;
#(
  parameter int DW    = RF_DW,
  parameter int AW    = RF_AW,
  parameter int DEPTH = RF_DEPTH,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int AXW = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  // Storage carries no reset; the decoder keeps illegal indices away.
  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < AXW'(DEPTH))) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if ({1'b0, raddr[p]} < AXW'(DEPTH)) rdata[p] = mem[raddr[p]];
      else                                rdata[p] = '0;
    end
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile
  import exu_rf_pkg::*;
#(
  parameter int DATA_W   = RF_DW,
  parameter int ADDR_W   = RF_AW,
  parameter int DEPTH    = RF_DEPTH,
  parameter int SINK_ADR = RF_SINK_ADR,
  parameter int FWD_ADR  = RF_FWD_ADR,
  parameter int MAR_ADR  = RF_MAR_ADR,
  parameter int FLD_ADR  = RF_FLD_ADR,
  parameter int ZERO_ADR = RF_ZERO_ADR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*ADDR_W-1:0]   addr_word,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_a_data,
  output logic [DATA_W-1:0]     rd_b_data,
  output logic                  rd_a_bad,
  output logic                  rd_b_bad,
  output logic                  wr_bad,
  output logic                  fwd_valid,
  output logic [DATA_W-1:0]     fwd_data,
  output logic [DATA_W-1:0]     mar_q,
  output logic [DATA_W-1:0]     fld_q
);
  localparam int NPORT = 3;  // A, B, C decoded alike
  localparam int NRD   = 2;

  logic [NPORT-1:0][ADDR_W-1:0] port_addr;
  rf_class_e                    port_cls [NPORT];
  logic [NRD-1:0][DATA_W-1:0]   arr_rd;
  logic [NRD-1:0][DATA_W-1:0]   rd_mux;
  logic [NRD-1:0]               rd_bad;

  // R9: field placement inside the packed address word
  assign port_addr = addr_word;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    exu_rf_decode #(
      .AW(ADDR_W), .DEPTH(DEPTH), .SINK_ADR(SINK_ADR), .FWD_ADR(FWD_ADR),
      .MAR_ADR(MAR_ADR), .FLD_ADR(FLD_ADR), .ZERO_ADR(ZERO_ADR)
    ) u_dec (
      .addr (port_addr[p]),
      .cls  (port_cls[p])
    );
  end

  logic c_store, c_mar, c_fld;
  assign c_store = wr_en && ((port_cls[2] == RC_STORE) || (port_cls[2] == RC_FLD));
  assign c_mar   = wr_en && (port_cls[2] == RC_MAR);
  assign c_fld   = wr_en && (port_cls[2] == RC_FLD);

  exu_rf_array #(
    .DW(DATA_W), .AW(ADDR_W), .DEPTH(DEPTH), .NRD(NRD)
  ) u_arr (
    .clk   (clk),
    .we    (c_store),
    .waddr (port_addr[2]),
    .wdata (wr_data),
    .raddr (port_addr[NRD-1:0]),
    .rdata (arr_rd)
  );

  // Next state for the two side registers
  logic [DATA_W-1:0] mar_d, fld_d;
  always_comb begin
    mar_d = mar_q;
    fld_d = fld_q;
    if (c_mar) mar_d = wr_data;
    if (c_fld) fld_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      fld_q <= '0;
    end else begin
      mar_q <= mar_d;
      fld_q <= fld_d;
    end
  end

  // Read multiplexing per read port
  for (genvar p = 0; p < NRD; p++) begin : g_rmux
    always_comb begin
      unique case (port_cls[p])
        RC_STORE: rd_mux[p] = arr_rd[p];
        RC_MAR:   rd_mux[p] = mar_q;
        RC_FLD:   rd_mux[p] = fld_q;
        default:  rd_mux[p] = '0;
      endcase
    end
    assign rd_bad[p] = (port_cls[p] == RC_BAD);
  end

  assign rd_a_data = rd_mux[0];
  assign rd_b_data = rd_mux[1];
  assign rd_a_bad  = rd_bad[0];
  assign rd_b_bad  = rd_bad[1];
  assign wr_bad    = wr_en && (port_cls[2] == RC_BAD);
  assign fwd_valid = wr_en && (port_cls[2] == RC_FWD);
  assign fwd_data  = fwd_valid ? wr_data : '0;

  // R4
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_word[3*ADDR_W-1:2*ADDR_W] == ADDR_W'(MAR_ADR)) |=> (mar_q == $past(wr_data)));

  // R5
  fld_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_word[3*ADDR_W-1:2*ADDR_W] == ADDR_W'(FLD_ADR)) |=> (fld_q == $past(wr_data)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mar_q) && $stable(fld_q)));

  // R8
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_bad |-> (rd_a_data == '0));

  // R3
  fwd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (wr_en && fwd_data == wr_data
                   && addr_word[3*ADDR_W-1:2*ADDR_W] == ADDR_W'(FWD_ADR)));
endmodule

// File: tb/sim_exu_regfile.sv
`timescale 1ns/1ps
module sim_exu_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr_word;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_a_data, rd_b_data, fwd_data, mar_q, fld_q;
  logic        rd_a_bad, rd_b_bad, wr_bad, fwd_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_mem [160];
  logic [31:0] m_mar, m_fld;

  always #5 clk = ~clk;

  exu_regfile u0 (
    .clk(clk), .rst_n(rst_n), .addr_word(addr_word), .wr_en(wr_en),
    .wr_data(wr_data), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .rd_a_bad(rd_a_bad), .rd_b_bad(rd_b_bad), .wr_bad(wr_bad),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .mar_q(mar_q), .fld_q(fld_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a >= 8'd160) return 32'h0;
    if (a == 8'd128 || a == 8'd129 || a == 8'd132) return 32'h0;
    if (a == 8'd130) return m_mar;
    if (a == 8'd131) return m_fld;
    return m_mem[a];
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a < 8'd128)  return "R1";
    if (a == 8'd128) return "R2";
    if (a == 8'd129) return "R3";
    if (a == 8'd130) return "R4";
    if (a == 8'd131) return "R5";
    if (a == 8'd132) return "R6";
    if (a < 8'd160)  return "R7";
    return "R8";
  endfunction

  function automatic logic [7:0] pick_addr();
    case ($urandom % 8)
      0, 1, 2, 3: return 8'($urandom % 128);
      4:          return 8'(128 + $urandom % 5);
      5:          return 8'(133 + $urandom % 27);
      6:          return 8'(160 + $urandom % 96);
      default:    return 8'($urandom % 256);
    endcase
  endfunction

  task automatic step(input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input bit we, input logic [31:0] d);
    @(negedge clk);
    addr_word = {c, b, a};  // R9 packing: C high, B middle, A low
    wr_en     = we;
    wr_data   = d;
    #1;
    chk(req_of(a), "port A read", rd_a_data, exp_rd(a));
    chk((a != b) ? "R9" : req_of(b), "port B read", rd_b_data, exp_rd(b));
    chk("R8", "rd_a_bad", 32'(rd_a_bad), 32'(a >= 8'd160));
    chk("R8", "rd_b_bad", 32'(rd_b_bad), 32'(b >= 8'd160));
    chk("R8", "wr_bad", 32'(wr_bad), 32'(we && c >= 8'd160));
    chk(we ? "R3" : "R12", "fwd_valid", 32'(fwd_valid), 32'(we && c == 8'd129));
    chk("R3", "fwd_data", fwd_data, (we && c == 8'd129) ? d : 32'h0);
    if (we && a == c) chk("R10", "old value on same-address read", rd_a_data, exp_rd(a));
    @(posedge clk);
    #1;
    if (we) begin
      if (c < 8'd128 || (c > 8'd132 && c < 8'd160) || c == 8'd131) m_mem[c] = d;
      if (c == 8'd130) m_mar = d;
      if (c == 8'd131) m_fld = d;
    end
    chk("R4", "mar_q", mar_q, m_mar);
    chk("R5", "fld_q", fld_q, m_fld);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; addr_word = '0; wr_en = 1'b0; wr_data = '0;
    m_mar = '0; m_fld = '0;
    for (int i = 0; i < 160; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "mar_q in reset", mar_q, 32'h0);
    chk("R11", "fld_q in reset", fld_q, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // Fill every address with a distinct pattern (specials included)
    for (int i = 0; i < 160; i++) step(8'd0, 8'd1, 8'(i), 1'b1, 32'hA500_0000 | 32'(i));
    // Read back everything, two at a time
    for (int i = 0; i < 160; i += 2) step(8'(i), 8'(i + 1), 8'd0, 1'b0, 32'hFFFF_FFFF);

    // Directed corners
    step(8'd129, 8'd128, 8'd129, 1'b1, 32'hDEAD_BEEF);   // R3 forward
    step(8'd132, 8'd132, 8'd132, 1'b1, 32'h1234_5678);   // R6 zero ignores write
    step(8'd132, 8'd128, 8'd128, 1'b1, 32'h8765_4321);   // R2 sink
    step(8'd5,   8'd5,   8'd5,   1'b1, 32'h0BAD_F00D);   // R10 no bypass
    step(8'd5,   8'd5,   8'd0,   1'b0, 32'h0);
    step(8'd200, 8'd255, 8'd160, 1'b1, 32'hCAFE_0001);   // R8 illegal write
    step(8'd32,  8'd0,   8'd255, 1'b1, 32'hCAFE_0002);   // R8 no wrap into low words
    step(8'd131, 8'd130, 8'd131, 1'b1, 32'h5A5A_5A5A);   // R5 both copies
    step(8'd131, 8'd130, 8'd130, 1'b1, 32'hC3C3_C3C3);   // R4
    step(8'd130, 8'd131, 8'd130, 1'b0, 32'h1111_1111);   // R12 disabled write

    for (int n = 0; n < 4000; n++)
      step(pick_addr(), pick_addr(), pick_addr(), ($urandom % 4) != 0, $urandom);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule